// File: doc/BRIEF.md
# Victim Buffer for a Direct-Mapped Cache

This block is a small fully-associative store that sits on the refill path of a direct-mapped first-level cache. The main cache forwards a lookup here whenever it misses. The lookup carries the requested line address and, when the main-cache set was occupied, the line that the incoming line will displace. The buffer compares the requested address against every stored entry in one cycle. On a match it returns the stored line, so the main cache pays a one-cycle penalty instead of a full refill. On no match it issues a refill request to the next memory level.

The buffer is filled with displaced lines, never with the line being fetched. On a hit the requested line leaves the buffer for the main cache, and the displaced line takes over the freed entry, so the two lines trade places. On a miss the displaced line goes into a free entry, or, when every entry is valid, replaces the least recently used one. Each entry keeps the full line address, because any main-cache set can land in any entry.

Top module: `victim_cache`

## Requirements
- R1: Any line address can be held in any of the ENTRIES entries (1 to 5, default 4), and at most one valid entry matches a given address.
- R2: A lookup presented with `req_valid` high at a clock edge produces `rsp_valid` high at the next edge. `rsp_hit` reports whether a valid entry held `req_addr` at the lookup edge, and on a hit `rsp_data` carries that entry's line.
- R3: On a hit with `ev_valid` high, the hit entry is overwritten with `ev_addr`/`ev_data`. A later lookup of the evicted address hits with the evicted data, and a later lookup of the requested address misses.
- R4: On a hit with `ev_valid` low, the hit entry becomes invalid, and a later lookup of that address misses.
- R5: On a miss, `refill_valid` is high and `refill_addr` equals the requested address in the same cycle as the response. On a hit, `refill_valid` stays low.
- R6: On a miss with `ev_valid` high, the evicted line is stored, and the requested address is not stored.
- R7: A stored evicted line goes to the lowest-numbered invalid entry. When all entries are valid, it replaces the entry whose last fill or swap is the oldest.
- R8: On a miss, `rsp_data` is all zeros.
- R9: Synchronous active-high `rst` invalidates every entry and clears all response outputs.
- R10: `ev_valid`, `ev_addr` and `ev_data` are ignored in any cycle where `req_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Main-cache miss lookup strobe |
| req_addr | input | ADDR_W | Requested line address |
| ev_valid | input | 1 | A displaced line accompanies the lookup |
| ev_addr | input | ADDR_W | Line address of the displaced line |
| ev_data | input | LINE_W | Contents of the displaced line |
| rsp_valid | output | 1 | Response strobe, one cycle after the lookup |
| rsp_hit | output | 1 | Lookup found the line in the buffer |
| rsp_data | output | LINE_W | Line returned on a hit, zero on a miss |
| refill_valid | output | 1 | Request to the next memory level |
| refill_addr | output | ADDR_W | Line address to fetch from the next level |

## Verification
The assertions rely on the main cache and the buffer holding disjoint lines. A displaced line therefore never already sits in the buffer and never equals the requested address, and this is what keeps matches unique. The bench holds to this rule because its random phase drives the lookups from its own direct-mapped cache model: every displaced line is the model's current occupant of the requested set, and every lookup is issued only after a main-cache miss. The directed phase picks distinct addresses by hand under the same rule, and it resets the buffer before the random phase so that no line from the directed phase is left behind.

// File: rtl/vc_pkg.sv
package vc_pkg;

    localparam int VC_ENTRIES = 4;
    localparam int VC_ADDR_W  = 12;
    localparam int VC_LINE_W  = 32;

    // what a lookup does to the buffer contents
    typedef enum logic [1:0] {
        VC_IDLE = 2'd0,
        VC_SWAP = 2'd1,   // hit, displaced line replaces the hit entry
        VC_FREE = 2'd2,   // hit, nothing displaced: entry released
        VC_FILL = 2'd3    // miss, displaced line stored in chosen entry
    } vc_act_e;

    function automatic int vc_idx_w(int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/vc_match.sv
module vc_match #(
    parameter int N      = vc_pkg::VC_ENTRIES,
    parameter int ADDR_W = vc_pkg::VC_ADDR_W,
    parameter int LINE_W = vc_pkg::VC_LINE_W,
    localparam int IDX_W = vc_pkg::vc_idx_w(N)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [N-1:0]                ent_vld,
    input  logic [N-1:0][ADDR_W-1:0]    ent_addr,
    input  logic [N-1:0][LINE_W-1:0]    ent_data,
    input  logic [ADDR_W-1:0]           look_addr,
    output logic                        hit,
    output logic [IDX_W-1:0]            hit_idx,
    output logic [LINE_W-1:0]           hit_data
);

    logic [N-1:0] match_v;

    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign match_v[i] = ent_vld[i] && (ent_addr[i] == look_addr);
    end

    always_comb begin
        hit      = |match_v;
        hit_idx  = '0;
        hit_data = '0;
        for (int i = 0; i < N; i++) begin
            if (match_v[i]) hit_idx = IDX_W'(i);
            hit_data = hit_data | ({LINE_W{match_v[i]}} & ent_data[i]);
        end
    end

    // R1: a line address is held by at most one valid entry
    p_unique_match_r1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(match_v));

endmodule

// File: rtl/vc_repl.sv
module vc_repl #(
    parameter int N      = vc_pkg::VC_ENTRIES,
    localparam int IDX_W = vc_pkg::vc_idx_w(N)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N-1:0]       ent_vld,
    input  logic               touch,
    input  logic [IDX_W-1:0]   touch_idx,
    output logic [IDX_W-1:0]   victim_idx
);

    // ages form a permutation of 0..N-1; 0 is most recent
    logic [N-1:0][IDX_W-1:0] age_q;
    logic [IDX_W-1:0]        touched_age;

    always_comb begin
        touched_age = '0;
        for (int i = 0; i < N; i++)
            if (touch_idx == IDX_W'(i)) touched_age = age_q[i];
    end

    for (genvar i = 0; i < N; i++) begin : g_age
        always_ff @(posedge clk) begin
            if (rst) begin
                age_q[i] <= IDX_W'(i);
            end else if (touch) begin
                if (touch_idx == IDX_W'(i))
                    age_q[i] <= '0;
                else if (age_q[i] < touched_age)
                    age_q[i] <= age_q[i] + 1'b1;
            end
        end

        // R7: the entry just filled or swapped becomes the youngest
        p_touch_youngest_r7: assert property (@(posedge clk) disable iff (rst)
            (touch && touch_idx == IDX_W'(i)) |=> (age_q[i] == '0));
    end

    always_comb begin
        logic found;
        found      = 1'b0;
        victim_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (!found && !ent_vld[i]) begin
                victim_idx = IDX_W'(i);
                found      = 1'b1;
            end
        end
        if (!found) begin
            for (int i = 0; i < N; i++)
                if (age_q[i] == IDX_W'(N-1)) victim_idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/victim_cache.sv
module victim_cache #(
    parameter int ENTRIES = vc_pkg::VC_ENTRIES,
    parameter int ADDR_W  = vc_pkg::VC_ADDR_W,
    parameter int LINE_W  = vc_pkg::VC_LINE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              ev_valid,
    input  logic [ADDR_W-1:0] ev_addr,
    input  logic [LINE_W-1:0] ev_data,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [LINE_W-1:0] rsp_data,
    output logic              refill_valid,
    output logic [ADDR_W-1:0] refill_addr
);
    import vc_pkg::*;

    localparam int IDX_W = vc_idx_w(ENTRIES);

    logic              vld_q  [ENTRIES];
    logic [ADDR_W-1:0] addr_q [ENTRIES];
    logic [LINE_W-1:0] data_q [ENTRIES];

    logic [ENTRIES-1:0]             vld_v;
    logic [ENTRIES-1:0][ADDR_W-1:0] addr_v;
    logic [ENTRIES-1:0][LINE_W-1:0] data_v;

    logic              hit;
    logic [IDX_W-1:0]  hit_idx;
    logic [LINE_W-1:0] hit_data;
    logic [IDX_W-1:0]  victim_idx;
    logic [IDX_W-1:0]  tgt_idx;
    vc_act_e           act;
    logic              touch;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_pack
        assign vld_v[i]  = vld_q[i];
        assign addr_v[i] = addr_q[i];
        assign data_v[i] = data_q[i];
    end

    vc_match #(.N(ENTRIES), .ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_match (
        .clk       (clk),
        .rst       (rst),
        .ent_vld   (vld_v),
        .ent_addr  (addr_v),
        .ent_data  (data_v),
        .look_addr (req_addr),
        .hit       (hit),
        .hit_idx   (hit_idx),
        .hit_data  (hit_data)
    );

    vc_repl #(.N(ENTRIES)) u_repl (
        .clk        (clk),
        .rst        (rst),
        .ent_vld    (vld_v),
        .touch      (touch),
        .touch_idx  (tgt_idx),
        .victim_idx (victim_idx)
    );

    always_comb begin
        act     = VC_IDLE;
        tgt_idx = hit_idx;
        if (req_valid) begin
            if (hit) begin
                act = ev_valid ? VC_SWAP : VC_FREE;
            end else if (ev_valid) begin
                act     = VC_FILL;
                tgt_idx = victim_idx;
            end
        end
    end

    assign touch = (act == VC_SWAP) || (act == VC_FILL);

    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                vld_q[i]  <= 1'b0;
                addr_q[i] <= '0;
                data_q[i] <= '0;
            end else if (tgt_idx == IDX_W'(i)) begin
                if (touch) begin
                    vld_q[i]  <= 1'b1;
                    addr_q[i] <= ev_addr;
                    data_q[i] <= ev_data;
                end else if (act == VC_FREE) begin
                    vld_q[i] <= 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid    <= 1'b0;
            rsp_hit      <= 1'b0;
            rsp_data     <= '0;
            refill_valid <= 1'b0;
            refill_addr  <= '0;
        end else begin
            rsp_valid    <= req_valid;
            rsp_hit      <= req_valid && hit;
            rsp_data     <= (req_valid && hit) ? hit_data : '0;
            refill_valid <= req_valid && !hit;
            refill_addr  <= (req_valid && !hit) ? req_addr : '0;
        end
    end

    // R2: every lookup is answered exactly one cycle later
    p_rsp_timing_r2: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    p_rsp_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    // R5: a response is either a hit or a refill, never both
    p_hit_xor_refill_r5: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_hit != refill_valid));
    p_refill_addr_r5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !hit) |=> (refill_addr == $past(req_addr)));

    // R3: a swap leaves the number of valid entries unchanged
    p_swap_count_r3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && hit && ev_valid) |=> ($countones(vld_v) == $past($countones(vld_v))));

    // R9: leaving reset, the buffer is empty
    p_reset_empty_r9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (vld_v == '0));

endmodule

// File: tb/tb_victim_cache.sv
module tb_victim_cache;

    localparam int CLK_PERIOD = 10;
    localparam int N      = 4;
    localparam int AW     = 12;
    localparam int LW     = 32;
    localparam int SETS   = 4;
    localparam int SPAN   = 24;
    localparam int ROUNDS = 3000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          ev_valid = 1'b0;
    logic [AW-1:0] ev_addr = '0;
    logic [LW-1:0] ev_data = '0;
    logic          rsp_valid, rsp_hit, refill_valid;
    logic [LW-1:0] rsp_data;
    logic [AW-1:0] refill_addr;

    int n_run  = 0;
    int n_fail = 0;

    // reference buffer model: valid, address, last-use stamp
    bit          m_vld [N];
    logic [AW-1:0] m_addr [N];
    int          m_stamp [N];
    int          now_stamp = 0;

    // direct-mapped main cache model for the random phase
    bit          c_vld [SETS];
    logic [AW-1:0] c_addr [SETS];

    always #(CLK_PERIOD/2) clk = ~clk;

    victim_cache #(.ENTRIES(N), .ADDR_W(AW), .LINE_W(LW)) dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_addr(req_addr),
        .ev_valid(ev_valid), .ev_addr(ev_addr), .ev_data(ev_data),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data),
        .refill_valid(refill_valid), .refill_addr(refill_addr)
    );

    function automatic logic [LW-1:0] line_of(logic [AW-1:0] a);
        return ({{(LW-AW){1'b0}}, a} * 32'h9E3779B1) ^ 32'h5A5A5A5A;
    endfunction

    task automatic check(bit ok, string tag, logic [LW-1:0] act, logic [LW-1:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic int ref_find(logic [AW-1:0] a);
        for (int i = 0; i < N; i++)
            if (m_vld[i] && m_addr[i] == a) return i;
        return -1;
    endfunction

    function automatic int ref_pick();
        int best;
        for (int i = 0; i < N; i++)
            if (!m_vld[i]) return i;
        best = 0;
        for (int i = 1; i < N; i++)
            if (m_stamp[i] < m_stamp[best]) best = i;
        return best;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < N; i++) m_vld[i] = 1'b0;
        for (int s = 0; s < SETS; s++) c_vld[s] = 1'b0;
    endtask

    // one lookup; checks the response against the reference model
    task automatic do_req(logic [AW-1:0] a, bit evv, logic [AW-1:0] ea, string tag);
        int mi;
        int slot;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        ev_valid  = evv;
        ev_addr   = ea;
        ev_data   = line_of(ea);
        mi = ref_find(a);
        @(negedge clk);
        req_valid = 1'b0;
        ev_valid  = 1'b0;
        check(rsp_valid == 1'b1, "R2 rsp_valid", LW'(rsp_valid), 1);
        check(rsp_hit == (mi >= 0), {tag, " hit"}, LW'(rsp_hit), LW'(mi >= 0));
        if (mi >= 0)
            check(rsp_data == line_of(a), "R2 data", rsp_data, line_of(a));
        else
            check(rsp_data == '0, "R8 miss data", rsp_data, 0);
        check(refill_valid == (mi < 0), "R5 refill_valid", LW'(refill_valid), LW'(mi < 0));
        if (mi < 0)
            check(refill_addr == a, "R5 refill_addr", LW'(refill_addr), LW'(a));
        now_stamp++;
        if (mi >= 0) begin
            if (evv) begin
                m_addr[mi]  = ea;
                m_stamp[mi] = now_stamp;
            end else begin
                m_vld[mi] = 1'b0;
            end
        end else if (evv) begin
            slot = ref_pick();
            m_vld[slot]   = 1'b1;
            m_addr[slot]  = ea;
            m_stamp[slot] = now_stamp;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9: reset state
        check(rsp_valid == 1'b0 && refill_valid == 1'b0, "R9 reset outputs",
              LW'({rsp_valid, refill_valid}), 0);
        for (int i = 0; i < N; i++) m_vld[i] = 1'b0;

        // R5 R8: empty buffer misses
        do_req(12'h010, 1'b0, 12'h000, "R5 empty");

        // R10: eviction without a lookup is dropped
        @(negedge clk);
        ev_valid = 1'b1; ev_addr = 12'h020; ev_data = line_of(12'h020);
        @(negedge clk);
        ev_valid = 1'b0;
        check(rsp_valid == 1'b0, "R10 no response", LW'(rsp_valid), 0);
        do_req(12'h020, 1'b0, 12'h000, "R10 ignored");

        // R6: fills store the displaced line, not the requested one
        do_req(12'h100, 1'b1, 12'h001, "R6 fill");
        do_req(12'h100, 1'b0, 12'h000, "R6 requested absent");
        do_req(12'h101, 1'b1, 12'h002, "R6 fill");
        do_req(12'h102, 1'b1, 12'h003, "R6 fill");
        do_req(12'h103, 1'b1, 12'h004, "R6 fill");

        // R4: hit without displaced line frees the entry
        do_req(12'h001, 1'b0, 12'h000, "R4 hit");
        do_req(12'h001, 1'b0, 12'h000, "R4 freed");

        // R7: free slot first, then least recently used
        do_req(12'h104, 1'b1, 12'h005, "R7 free slot");
        do_req(12'h105, 1'b1, 12'h006, "R7 lru fill");
        do_req(12'h002, 1'b0, 12'h000, "R7 oldest gone");
        do_req(12'h005, 1'b0, 12'h000, "R7 recent kept");

        // R3: swap
        do_req(12'h003, 1'b1, 12'h007, "R3 swap hit");
        do_req(12'h003, 1'b0, 12'h000, "R3 requested gone");
        do_req(12'h007, 1'b0, 12'h000, "R3 evicted present");

        // R9: reset clears stored lines
        do_reset();
        do_req(12'h004, 1'b0, 12'h000, "R9 cleared");

        // R1: random traffic through a direct-mapped main cache model
        do_reset();
        begin
            logic [31:0] seed;
            seed = 32'h0000_1234;
            for (int r = 0; r < ROUNDS; r++) begin
                logic [AW-1:0] a;
                int s;
                seed = seed * 32'd1664525 + 32'd1013904223;
                a = AW'((seed >> 16) % SPAN);
                s = int'(a) % SETS;
                if (((seed >> 8) & 32'h7) == 0) begin
                    c_vld[s] = 1'b0;   // drop main-cache line: exercises R4
                end else if (!(c_vld[s] && c_addr[s] == a)) begin
                    do_req(a, c_vld[s], c_vld[s] ? c_addr[s] : '0, "R1 random");
                    c_vld[s]  = 1'b1;
                    c_addr[s] = a;
                end
            end
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule